// File: doc/BRIEF.md
# Character LCD Parallel Bus Master

This block is the host side of the parallel interface used by character LCD modules. A requester hands it one transfer at a time over a valid/ready handshake. A transfer is either a write of a byte to the instruction register or the data register, or a read of the data register or the busy/address status. The block then sequences the register-select, read/write and enable strobes, and it drives or samples the data lines. Read results come back with a one-cycle done strobe.

Every interval is counted in clock cycles. The counts come from a clock-frequency parameter and nanosecond parameters: the address setup before the enable strobe, the width of the enable pulse, the data hold after the strobe, and the execution wait after a write. A build-time switch picks the bus width. With eight lines, a byte moves in a single strobe. With four lines, a byte moves as two strobes, high half first. The pads stay outside the block, so it exposes separate data-out, data-in and output-enable signals.

Top module: `lcd_bus_master`

## Requirements
- R1: A write holds `lcd_rw` low and keeps `bus_oe` high. `lcd_rs` is low when `req_rs`=0 (instruction) and high when `req_rs`=1 (data). The byte appears on `bus_dout`.
- R2: A read (`req_read`=1) holds `lcd_rw` high. `lcd_rs` is high for a data read (`req_rs`=1) and low for a status read (`req_rs`=0).
- R3: `lcd_e` rises exactly SETUP_CYC cycles after the clock edge that accepts the request. Between the halves of a four-line transfer it rises HOLD_CYC+SETUP_CYC cycles after the previous fall. Here X_CYC = max(1, ceil(X_NS·CLK_HZ/1e9)).
- R4: `lcd_e` stays high for exactly PULSE_CYC cycles. `bus_dout`, `lcd_rs` and `lcd_rw` do not change while it is high or during the HOLD_CYC cycles after it falls.
- R5: With MODE_4BIT=1, each byte takes two strobes. The first carries bits 7:4 and the second carries bits 3:0. Nibble bit 0 is on `bus_dout[0]`/`bus_din[0]` (line D4) and nibble bit 3 is on index 3 (line D7).
- R6: With MODE_4BIT=0, each byte takes a single strobe, with byte bit n on line index n.
- R7: A read returns `rd_data`, valid while `rd_done` pulses for one cycle. `rd_done` comes HOLD_CYC cycles after the last strobe falls. In four-line mode `rd_data` = (first nibble << 4) | second nibble, with each nibble sampled in the last cycle of its strobe.
- R8: During a read, `bus_oe` is low from the cycle after acceptance until the transfer completes. It is low at least one cycle before `lcd_e` rises, and never high while `lcd_e` and `lcd_rw` are both high.
- R9: After the last strobe of a write, `req_ready` returns high exactly HOLD_CYC+EXEC_CYC cycles after the fall.
- R10: `req_ready` is high only in idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_valid` is ignored while `req_ready` is low. A request waiting when a read finishes is taken in the same cycle as `rd_done`.
- R11: After reset, `lcd_e`, `lcd_rw`, `lcd_rs` and `rd_done` are low, and `bus_oe` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_rs | input | 1 | 1 = data register, 0 = instruction/status |
| req_wdata | input | 8 | Byte to write |
| rd_done | output | 1 | One-cycle strobe, read byte valid |
| rd_data | output | 8 | Read byte |
| lcd_rs | output | 1 | Register select line |
| lcd_rw | output | 1 | Read/write line, high for read |
| lcd_e | output | 1 | Enable strobe |
| bus_dout | output | BUS_W (4 or 8) | Data driven to the lines |
| bus_din | input | BUS_W (4 or 8) | Data sampled from the lines |
| bus_oe | output | 1 | Host drives the lines when high |

## Verification
Two events can land on the same cycle: the completion strobe of a read and the acceptance of the next request. The bench holds `req_valid` high from just after a read is accepted, with a write queued behind it. It checks that `rd_data` is correct in the cycle where `rd_done` and `req_ready` rise together. In the very next cycle the queued write must already own the bus: `req_ready` low, `lcd_rw` low and `bus_oe` high. Request pulses in the middle of a strobe are also injected, and must leave the ongoing transfer and the later idle bus untouched.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_EXEC
    } lcd_state_e;

    typedef struct packed {
        lcd_state_e state;
        logic       rs;
        logic       rw;
        logic       oe;
        logic       e;
        logic       nib;    // 0: high half or whole byte, 1: low half
        logic       done;
        logic [7:0] wbyte;
    } lcd_ctl_t;

    // Convert a duration in ns to clock cycles, rounding up, at least 1.
    function automatic int unsigned ns_to_cycles(longint unsigned ns,
                                                 longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/lcd_interval_timer.sv
module lcd_interval_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_lane_select.sv
module lcd_lane_select #(
    parameter bit MODE_4BIT = 1'b1,
    parameter int BUS_W     = MODE_4BIT ? 4 : 8
) (
    input  logic [7:0]       wbyte,
    input  logic             nib,
    output logic [BUS_W-1:0] lanes
);
    generate
        if (MODE_4BIT) begin : g_half
            assign lanes = nib ? wbyte[3:0] : wbyte[7:4];
        end else begin : g_full
            logic unused_nib;
            assign unused_nib = nib;
            assign lanes = wbyte;
        end
    endgenerate
endmodule

// File: rtl/lcd_read_merge.sv
module lcd_read_merge #(
    parameter bit MODE_4BIT = 1'b1,
    parameter int BUS_W     = MODE_4BIT ? 4 : 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             nib,
    input  logic [BUS_W-1:0] lanes,
    output logic [7:0]       rbyte
);
    generate
        if (MODE_4BIT) begin : g_half
            logic [3:0] hi_d, hi_q, lo_d, lo_q;
            always_comb begin
                hi_d = hi_q;
                lo_d = lo_q;
                if (capture && !nib) hi_d = lanes;
                if (capture &&  nib) lo_d = lanes;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hi_q <= '0;
                    lo_q <= '0;
                end else begin
                    hi_q <= hi_d;
                    lo_q <= lo_d;
                end
            end
            assign rbyte = {hi_q, lo_q};
        end else begin : g_full
            logic [7:0] b_d, b_q;
            logic       unused_nib;
            assign unused_nib = nib;
            always_comb b_d = capture ? lanes : b_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) b_q <= '0;
                else        b_q <= b_d;
            end
            assign rbyte = b_q;
        end
    endgenerate
endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
    import lcd_bus_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 64'd50_000_000,
    parameter bit              MODE_4BIT = 1'b1,
    parameter longint unsigned SETUP_NS  = 64'd60,
    parameter longint unsigned PULSE_NS  = 64'd450,
    parameter longint unsigned HOLD_NS   = 64'd20,
    parameter longint unsigned EXEC_NS   = 64'd37_000,
    localparam int             BUS_W     = MODE_4BIT ? 4 : 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_read,
    input  logic             req_rs,
    input  logic [7:0]       req_wdata,
    output logic             rd_done,
    output logic [7:0]       rd_data,
    output logic             lcd_rs,
    output logic             lcd_rw,
    output logic             lcd_e,
    output logic [BUS_W-1:0] bus_dout,
    input  logic [BUS_W-1:0] bus_din,
    output logic             bus_oe
);
    localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_HZ);
    localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_HZ);
    localparam int HOLD_CYC  = ns_to_cycles(HOLD_NS,  CLK_HZ);
    localparam int EXEC_CYC  = ns_to_cycles(EXEC_NS,  CLK_HZ);
    localparam int MAX_A     = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_B     = (HOLD_CYC  > EXEC_CYC)  ? HOLD_CYC  : EXEC_CYC;
    localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_EXEC  = CNT_W'(EXEC_CYC - 1);

    lcd_ctl_t         r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             capture;

    lcd_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lcd_lane_select #(.MODE_4BIT(MODE_4BIT), .BUS_W(BUS_W)) u_lanes (
        .wbyte (r_q.wbyte),
        .nib   (r_q.nib),
        .lanes (bus_dout)
    );

    lcd_read_merge #(.MODE_4BIT(MODE_4BIT), .BUS_W(BUS_W)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .nib     (r_q.nib),
        .lanes   (bus_din),
        .rbyte   (rd_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.rs    = req_rs;
                    r_d.rw    = req_read;
                    r_d.oe    = ~req_read;
                    r_d.wbyte = req_wdata;
                    r_d.nib   = 1'b0;
                    r_d.state = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    r_d.e     = 1'b1;
                    r_d.state = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    r_d.e     = 1'b0;
                    r_d.state = ST_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_HOLD;
                    capture   = r_q.rw;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    if (MODE_4BIT && !r_q.nib) begin
                        r_d.nib   = 1'b1;
                        r_d.state = ST_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_SETUP;
                    end else if (r_q.rw) begin
                        r_d.done  = 1'b1;
                        r_d.rw    = 1'b0;
                        r_d.oe    = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_EXEC;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                if (tmr_expired) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.oe    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rd_done   = r_q.done;
    assign lcd_rs    = r_q.rs;
    assign lcd_rw    = r_q.rw;
    assign lcd_e     = r_q.e;
    assign bus_oe    = r_q.oe;
endmodule

// File: rtl/lcd_bus_master_chk.sv
module lcd_bus_master_chk #(
    parameter int BUS_W     = 4,
    parameter int PULSE_CYC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rd_done,
    input logic             lcd_e,
    input logic             lcd_rs,
    input logic             lcd_rw,
    input logic             bus_oe,
    input logic [BUS_W-1:0] bus_dout
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_cnt <= '0;
        else if (lcd_e) hi_cnt <= hi_cnt + 16'd1;
        else            hi_cnt <= '0;
    end

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && lcd_rw) |-> !bus_oe);

    assert_oe_off_before_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_e) && lcd_rw) |-> !$past(bus_oe));

    assert_write_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !lcd_rw) |-> bus_oe);

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (hi_cnt == 16'(PULSE_CYC)));

    assert_hold_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> ($stable(bus_dout) && $stable(lcd_rs) && $stable(lcd_rw)));

    assert_strobe_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(bus_dout)));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (req_ready && !lcd_e));
endmodule

bind lcd_bus_master lcd_bus_master_chk #(
    .BUS_W     (BUS_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_done   (rd_done),
    .lcd_e     (lcd_e),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .bus_oe    (bus_oe),
    .bus_dout  (bus_dout)
);

// File: tb/lcd_bus_master_tb.sv
module lcd_bus_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned HZ = 64'd100_000_000;
    localparam longint unsigned EXEC_NS_TB = 64'd600;
    // Expected cycle counts: ceil(ns * 100 MHz / 1e9)
    localparam int S_CYC = 6;
    localparam int P_CYC = 45;
    localparam int H_CYC = 2;
    localparam int X_CYC = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       v   [2];
    logic       rd  [2];
    logic       rsq [2];
    logic [7:0] wd  [2];
    logic       rdy [2];
    logic       done[2];
    logic [7:0] rdat[2];
    logic       e   [2];
    logic       rs  [2];
    logic       rw  [2];
    logic       oe  [2];
    logic [3:0] dout4, din4;
    logic [7:0] dout8, din8;
    logic [7:0] model_byte;
    logic       idx4, pe4;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    lcd_bus_master #(.CLK_HZ(HZ), .MODE_4BIT(1'b1), .EXEC_NS(EXEC_NS_TB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_ready(rdy[0]),
        .req_read(rd[0]), .req_rs(rsq[0]), .req_wdata(wd[0]),
        .rd_done(done[0]), .rd_data(rdat[0]), .lcd_rs(rs[0]), .lcd_rw(rw[0]),
        .lcd_e(e[0]), .bus_dout(dout4), .bus_din(din4), .bus_oe(oe[0]));

    lcd_bus_master #(.CLK_HZ(HZ), .MODE_4BIT(1'b0), .EXEC_NS(EXEC_NS_TB)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_ready(rdy[1]),
        .req_read(rd[1]), .req_rs(rsq[1]), .req_wdata(wd[1]),
        .rd_done(done[1]), .rd_data(rdat[1]), .lcd_rs(rs[1]), .lcd_rw(rw[1]),
        .lcd_e(e[1]), .bus_dout(dout8), .bus_din(din8), .bus_oe(oe[1]));

    // Display model: halves served high first, switching at each strobe fall.
    always @(negedge clk) begin
        pe4 <= e[0];
        if (rdy[0])           idx4 <= 1'b0;
        else if (pe4 && !e[0]) idx4 <= ~idx4;
    end
    assign din4 = idx4 ? model_byte[3:0] : model_byte[7:4];
    assign din8 = model_byte;

    function automatic logic [7:0] busval(int s);
        return (s == 0) ? {4'h0, dout4} : dout8;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(int s, bit isrd, bit rsv, logic [7:0] b, bit poke);
        int np = (s == 0) ? 2 : 1;
        int lowc, hic, tc;
        logic [7:0] first, expv;
        model_byte = b;
        while (!rdy[s]) @(negedge clk);
        v[s] = 1'b1; rd[s] = isrd; rsq[s] = rsv; wd[s] = isrd ? ~b : b;
        @(negedge clk);
        v[s] = 1'b0;
        chk(rs[s] == rsv, isrd ? "R2" : "R1", "rs level", int'(rs[s]), int'(rsv));
        chk(rw[s] == isrd, isrd ? "R2" : "R1", "rw level", int'(rw[s]), int'(isrd));
        chk(oe[s] == !isrd, "R8", "oe after accept", int'(oe[s]), int'(!isrd));
        for (int p = 0; p < np; p++) begin
            logic last_oe = oe[s];
            lowc = 0;
            while (!e[s] && lowc < 1000) begin
                lowc++; last_oe = oe[s]; @(negedge clk);
            end
            chk(lowc == ((p == 0) ? S_CYC : H_CYC + S_CYC), "R3", "setup cycles",
                lowc, (p == 0) ? S_CYC : H_CYC + S_CYC);
            if (isrd) chk(last_oe == 1'b0, "R8", "oe before strobe", int'(last_oe), 0);
            hic = 0;
            first = busval(s);
            while (e[s] && hic < 1000) begin
                hic++;
                if (busval(s) != first || rs[s] != rsv || rw[s] != isrd)
                    chk(1'b0, "R4", "lines moved in strobe", int'(busval(s)), int'(first));
                if (isrd && oe[s]) chk(1'b0, "R8", "oe high in read strobe", 1, 0);
                if (poke && hic == 3) begin
                    v[s] = 1'b1; rd[s] = ~isrd; rsq[s] = ~rsv; wd[s] = ~b;
                end
                if (poke && hic == 5) v[s] = 1'b0;
                @(negedge clk);
            end
            chk(hic == P_CYC, "R4", "strobe width", hic, P_CYC);
            if (!isrd) begin
                expv = (s == 0) ? ((p == 0) ? {4'h0, b[7:4]} : {4'h0, b[3:0]}) : b;
                chk(first == expv, (s == 0) ? "R5" : "R6", "lanes", int'(first), int'(expv));
                chk(busval(s) == first, "R4", "hold data", int'(busval(s)), int'(first));
            end
        end
        tc = 0;
        while (!rdy[s] && tc < 1000) begin
            if (done[s]) chk(1'b0, "R7", "early done", 1, 0);
            tc++; @(negedge clk);
        end
        chk(tc == (isrd ? H_CYC : H_CYC + X_CYC), isrd ? "R7" : "R9", "tail cycles",
            tc, isrd ? H_CYC : H_CYC + X_CYC);
        chk(done[s] == isrd, "R7", "done strobe", int'(done[s]), int'(isrd));
        if (isrd) chk(rdat[s] == b, "R7", "read byte", int'(rdat[s]), int'(b));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        int g;
        for (int s = 0; s < 2; s++) begin
            v[s] = 1'b0; rd[s] = 1'b0; rsq[s] = 1'b0; wd[s] = 8'h00;
        end
        model_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state of both variants
        for (int s = 0; s < 2; s++) begin
            chk(!e[s] && !rw[s] && !rs[s] && !done[s], "R11", "strobes after reset",
                int'({e[s], rw[s], rs[s], done[s]}), 0);
            chk(oe[s] && rdy[s], "R11", "oe/ready after reset", int'({oe[s], rdy[s]}), 3);
        end
        // R1 R5 R9: every byte written over four lines
        for (int b = 0; b < 256; b++) xfer(0, 1'b0, b[0] ^ b[7], 8'(b), 1'b0);
        // R2 R5 R7: every byte read over four lines, data and status reads
        for (int b = 0; b < 256; b++) xfer(0, 1'b1, b[1], 8'(b), 1'b0);
        // R6: eight-line writes and reads
        for (int b = 0; b < 256; b += 5) xfer(1, 1'b0, b[0], 8'(b), 1'b0);
        for (int b = 3; b < 256; b += 7) xfer(1, 1'b1, b[0], 8'(b), 1'b0);
        // R10: requests pulsed mid-strobe are ignored
        xfer(0, 1'b0, 1'b1, 8'h3C, 1'b1);
        xfer(1, 1'b1, 1'b0, 8'hC3, 1'b1);
        for (int s = 0; s < 2; s++) begin
            g = 0;
            for (int k = 0; k < 20; k++) begin
                if (e[s] || !rdy[s]) g++;
                @(negedge clk);
            end
            chk(g == 0, "R10", "bus quiet after ignored request", g, 0);
        end
        // R10 R7: queued write accepted in the cycle of read completion
        model_byte = 8'h96;
        v[0] = 1'b1; rd[0] = 1'b1; rsq[0] = 1'b1; wd[0] = 8'h00;
        @(negedge clk);
        rd[0] = 1'b0; rsq[0] = 1'b0; wd[0] = 8'hA5;
        g = 0;
        while (!done[0] && g < 1000) begin g++; @(negedge clk); end
        chk(rdat[0] == 8'h96, "R7", "back-to-back read byte", int'(rdat[0]), 8'h96);
        chk(rdy[0] == 1'b1, "R10", "ready with done", int'(rdy[0]), 1);
        @(negedge clk);
        v[0] = 1'b0;
        chk(!rdy[0] && !rw[0] && !rs[0] && oe[0], "R10", "queued write owns bus",
            int'({rdy[0], rw[0], rs[0], oe[0]}), 1);
        g = 0;
        first_half: while (!e[0] && g < 1000) begin g++; @(negedge clk); end
        chk(dout4 == 4'hA, "R5", "queued write high half", int'(dout4), 4'hA);
        while (!rdy[0]) @(negedge clk);
        summary();
    end
endmodule